// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block is the digital conversion-control core of a sampling analog-to-digital converter. A conversion can be launched in two ways. The first is a rising edge on the external start pin, which puts the track/hold into hold and begins the conversion on the next clock with no added delay. The second is a write to the 6-bit control register with its start bit set. In that case an internal acquisition-length delay runs first, and hold and conversion begin only when the delay has ended. Because of this delay, a single write can both select a new input channel and request a conversion, and the sample is still taken after the input has settled.

The conversion itself is timed by the internal free-running clock and lasts a fixed number of cycles. When it ends, the track output returns high, which begins the next acquisition period. At the same edge the result register captures the 12-bit value on the behavioural converter data input, and the active-low end-of-conversion output pulses low for a parameterised number of cycles. A start request that arrives while a sequence (acquisition delay, conversion or end pulse) is in progress is ignored.

Top module: `adcc_start_ctrl`

## Requirements
- R1: After reset, track is 1, eoc_n is 1, result is 0 and ctrl_o is 0.
- R2: When a rising edge on convst is sampled while the block is idle, track is 0 from the next clock edge onward.
- R3: track stays 0 for exactly CONV_CYCLES clock cycles. It then returns to 1, and eoc_n goes to 0 at the same edge.
- R4: At the edge where eoc_n falls, result takes the value of sar_data sampled at that edge. At all other times result holds its value.
- R5: eoc_n stays 0 for exactly EOC_CYCLES cycles, and the block then becomes idle.
- R6: A write in the idle state with bit 5 (start) of ctrl_wdata set makes ctrl_o[5] read 1. track then stays 1 for ACQ_CYCLES cycles after the write edge before it falls.
- R7: ctrl_o[5] clears on the same edge at which track falls after a software start.
- R8: Every write stores ctrl_wdata[4:0] into ctrl_o[4:0] (channel in bits 2:0, format in bit 3, auxiliary in bit 4), whatever the state.
- R9: Start requests (a convst rising edge or a write with bit 5 set) outside the idle state are ignored. No extra conversion follows, and ctrl_o[5] stays 0.
- R10: If a convst rising edge and a start write arrive in the same idle cycle, the hardware start wins: track falls at the next edge and ctrl_o[5] stays 0.
- R11: Only a rising edge starts a conversion. A convst held high does not start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| convst | input | 1 | Hardware start pin, acts on its rising edge |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control write data: [2:0] channel, [3] format, [4] auxiliary, [5] start |
| sar_data | input | 12 | Behavioural converter result |
| track | output | 1 | 1 = track, 0 = hold |
| eoc_n | output | 1 | Active-low end-of-conversion pulse |
| result | output | 12 | Output result register |
| ctrl_o | output | 6 | Control register contents |

## Verification
The bench sweeps all eight channels and both format values through software starts, and runs hardware starts with many data values. For each conversion it measures the acquisition delay, the hold length and the end-pulse length in cycles. A design that started hold at the write would give a zero acquisition count. A design with an off-by-one timer would give a wrong hold or pulse width. Further tests put hardware edges and start writes inside a running sequence, send both kinds of start in one cycle, and hold convst high. A design that re-armed early, let the software start win, or acted on the level of convst would then show an extra fall of track or a start bit left set.

// File: rtl/adcc_pkg.sv
package adcc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2,
        PH_EOC  = 2'd3
    } phase_e;

    localparam int CTRL_W    = 6;
    localparam int CH_LSB    = 0;
    localparam int CH_W      = 3;
    localparam int FMT_BIT   = 3;
    localparam int AUX_BIT   = 4;
    localparam int START_BIT = 5;
endpackage

// File: rtl/adcc_edge.sv
module adcc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_s;

    edge_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = pin & ~st_q.prev;

    // R11
    rise_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/adcc_timer.sv
module adcc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_s;

    tmr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)
            st_d.cnt = load_val;
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign zero = (st_q.cnt == '0);

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);
endmodule

// File: rtl/adcc_ctrl_reg.sv
module adcc_ctrl_reg
    import adcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              start_ok,
    input  logic              start_clr,
    output logic              start_req,
    output logic [CTRL_W-1:0] ctrl_q
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } reg_s;

    reg_s st_d, st_q;

    assign start_req = wr & wdata[START_BIT] & start_ok;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.ctrl[START_BIT-1:0] = wdata[START_BIT-1:0];
            if (start_req)
                st_d.ctrl[START_BIT] = 1'b1;
        end
        if (start_clr)
            st_d.ctrl[START_BIT] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q = st_q.ctrl;

    // R8
    low_bits_follow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ctrl_q[START_BIT-1:0] == $past(wdata[START_BIT-1:0]));
    // R9
    start_only_when_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[START_BIT]) |-> $past(start_ok) && $past(wr));
endmodule

// File: rtl/adcc_start_ctrl.sv
module adcc_start_ctrl
    import adcc_pkg::*;
#(
    parameter int ACQ_CYCLES  = 20,
    parameter int CONV_CYCLES = 80,
    parameter int EOC_CYCLES  = 2,
    parameter int DATA_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              convst,
    input  logic              ctrl_wr,
    input  logic [5:0]        ctrl_wdata,
    input  logic [DATA_W-1:0] sar_data,
    output logic              track,
    output logic              eoc_n,
    output logic [DATA_W-1:0] result,
    output logic [5:0]        ctrl_o
);
    localparam int MAXC = (ACQ_CYCLES > CONV_CYCLES)
                          ? ((ACQ_CYCLES > EOC_CYCLES) ? ACQ_CYCLES : EOC_CYCLES)
                          : ((CONV_CYCLES > EOC_CYCLES) ? CONV_CYCLES : EOC_CYCLES);
    localparam int TW = $clog2(MAXC + 1);
    localparam logic [TW-1:0] ACQ_LD  = TW'(ACQ_CYCLES - 1);
    localparam logic [TW-1:0] CONV_LD = TW'(CONV_CYCLES - 1);
    localparam logic [TW-1:0] EOC_LD  = TW'(EOC_CYCLES - 1);

    typedef struct packed {
        phase_e            ph;
        logic              track;
        logic              eoc_n;
        logic [DATA_W-1:0] result;
    } top_s;

    top_s st_d, st_q;

    logic          hw_rise;
    logic          sw_req;
    logic          idle;
    logic          start_ok;
    logic          start_clr;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;

    adcc_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (convst),
        .rise (hw_rise)
    );

    adcc_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    assign idle     = (st_q.ph == PH_IDLE);
    assign start_ok = idle & ~hw_rise;

    adcc_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctrl_wr),
        .wdata    (ctrl_wdata),
        .start_ok (start_ok),
        .start_clr(start_clr),
        .start_req(sw_req),
        .ctrl_q   (ctrl_o)
    );

    always_comb begin
        st_d      = st_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        start_clr = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (hw_rise) begin
                    st_d.ph    = PH_CONV;
                    st_d.track = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = CONV_LD;
                end else if (sw_req) begin
                    st_d.ph  = PH_ACQ;
                    tmr_load = 1'b1;
                    tmr_val  = ACQ_LD;
                end
            end
            PH_ACQ: begin
                if (tmr_zero) begin
                    st_d.ph    = PH_CONV;
                    st_d.track = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = CONV_LD;
                    start_clr  = 1'b1;
                end
            end
            PH_CONV: begin
                if (tmr_zero) begin
                    st_d.ph     = PH_EOC;
                    st_d.track  = 1'b1;
                    st_d.eoc_n  = 1'b0;
                    st_d.result = sar_data;
                    tmr_load    = 1'b1;
                    tmr_val     = EOC_LD;
                end
            end
            PH_EOC: begin
                if (tmr_zero) begin
                    st_d.ph    = PH_IDLE;
                    st_d.eoc_n = 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph     <= PH_IDLE;
            st_q.track  <= 1'b1;
            st_q.eoc_n  <= 1'b1;
            st_q.result <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign track  = st_q.track;
    assign eoc_n  = st_q.eoc_n;
    assign result = st_q.result;

    // Pulse-width counters used only by the checks below
    localparam int HW = $clog2(MAXC + 2) + 1;
    logic [HW-1:0] hold_len_q;
    logic [HW-1:0] eoc_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_len_q <= '0;
            eoc_len_q  <= '0;
        end else begin
            hold_len_q <= track ? '0 : hold_len_q + 1'b1;
            eoc_len_q  <= eoc_n ? '0 : eoc_len_q + 1'b1;
        end
    end

    // R2
    hw_start_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && hw_rise) |=> !track);
    // R3
    hold_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(track) |-> hold_len_q == HW'(CONV_CYCLES));
    // R3
    eoc_with_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(track) |-> $fell(eoc_n));
    // R4
    result_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n) |-> result == $past(sar_data));
    // R4
    result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(eoc_n) |-> $stable(result));
    // R5
    eoc_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_n) |-> eoc_len_q == HW'(EOC_CYCLES));
    // R7
    start_bit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_o[START_BIT]) |-> $fell(track));
    // R10
    hw_beats_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && hw_rise) |=> !ctrl_o[START_BIT]);
endmodule

// File: tb/test_adcc_start_ctrl.sv
module test_adcc_start_ctrl;
    localparam int ACQ  = 3;
    localparam int CONV = 5;
    localparam int EOCL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        convst = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [5:0]  ctrl_wdata = '0;
    logic [11:0] sar_data = '0;
    logic        track;
    logic        eoc_n;
    logic [11:0] result;
    logic [5:0]  ctrl_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    adcc_start_ctrl #(.ACQ_CYCLES(ACQ), .CONV_CYCLES(CONV), .EOC_CYCLES(EOCL),
                      .DATA_W(12)) i_adcc_start_ctrl (
        .clk(clk), .rst_n(rst_n), .convst(convst), .ctrl_wr(ctrl_wr),
        .ctrl_wdata(ctrl_wdata), .sar_data(sar_data), .track(track),
        .eoc_n(eoc_n), .result(result), .ctrl_o(ctrl_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at the negedge where track is first seen low; measures hold and end pulse
    task automatic finish_conv(input logic [11:0] d, input string tag);
        int k = 1;
        int e = 1;
        while (track == 1'b0 && k < 100) begin
            @(negedge clk);
            if (track == 1'b0) k++;
        end
        check({"R3 hold length ", tag}, k, CONV);
        check({"R3 eoc low at track rise ", tag}, int'(eoc_n), 0);
        check({"R4 result ", tag}, int'(result), int'(d));
        while (eoc_n == 1'b0 && e < 100) begin
            @(negedge clk);
            if (eoc_n == 1'b0) e++;
        end
        check({"R5 eoc length ", tag}, e, EOCL);
    endtask

    task automatic hw_conv(input logic [11:0] d);
        @(negedge clk);
        sar_data = d;
        convst = 1'b1;
        @(negedge clk);
        convst = 1'b0;
        check("R2 track low after hw edge", int'(track), 0);
        finish_conv(d, "hw");
    endtask

    task automatic sw_conv(input logic [4:0] low, input logic [11:0] d);
        int a = 1;
        @(negedge clk);
        sar_data = d;
        ctrl_wr = 1'b1;
        ctrl_wdata = {1'b1, low};
        @(negedge clk);
        ctrl_wr = 1'b0;
        check("R6 start bit set", int'(ctrl_o), int'({1'b1, low}));
        check("R6 track high after write", int'(track), 1);
        while (track == 1'b1 && a < 100) begin
            @(negedge clk);
            if (track == 1'b1) a++;
        end
        check("R6 acquisition delay", a, ACQ);
        check("R7 start bit cleared at hold", int'(ctrl_o), int'({1'b0, low}));
        finish_conv(d, "sw");
    endtask

    task automatic quiet(input int n, input string req);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (track == 1'b0) lows++;
        end
        check(req, lows, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 track", int'(track), 1);
        check("R1 eoc_n", int'(eoc_n), 1);
        check("R1 result", int'(result), 0);
        check("R1 ctrl", int'(ctrl_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 R7 R8: every channel and format through software starts
        for (int ch = 0; ch < 8; ch++) begin
            for (int f = 0; f < 2; f++) begin
                sw_conv({f[0] ^ ch[0], f[0], ch[2:0]}, 12'((ch * 517 + f * 1999 + 123) & 12'hFFF));
            end
        end

        // R2 R3 R4 R5: hardware starts with varied data
        for (int i = 0; i < 16; i++) begin
            hw_conv(12'((i * 273 + 4095 - i) & 12'hFFF));
        end

        // R9 R8: requests during conversion are ignored, low bits still written
        @(negedge clk);
        sar_data = 12'hA5C;
        convst = 1'b1;
        @(negedge clk);
        convst = 1'b0;
        ctrl_wr = 1'b1;
        ctrl_wdata = 6'b1_01_110;
        @(negedge clk);
        ctrl_wr = 1'b0;
        check("R9 start bit ignored in hold", int'(ctrl_o[5]), 0);
        check("R8 low bits written in hold", int'(ctrl_o[4:0]), 5'b01_110);
        convst = 1'b1;
        @(negedge clk);
        convst = 1'b0;
        while (track == 1'b0) @(negedge clk);
        // now in end pulse: another request
        ctrl_wr = 1'b1;
        ctrl_wdata = 6'b1_10_001;
        convst = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
        convst = 1'b0;
        check("R9 start bit ignored in eoc", int'(ctrl_o[5]), 0);
        check("R8 low bits written in eoc", int'(ctrl_o[4:0]), 5'b10_001);
        check("R4 result of ignored-run", int'(result), 12'hA5C);
        quiet(12, "R9 no extra conversion");

        // R9: requests during acquisition delay
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = 6'b1_00_011;
        @(negedge clk);
        ctrl_wr = 1'b0;
        convst = 1'b1;
        @(negedge clk);
        convst = 1'b0;
        check("R9 hw edge ignored in acq", int'(track), 1);
        while (track == 1'b1) @(negedge clk);
        finish_conv(sar_data, "acq-ignore");
        quiet(12, "R9 no conversion after acq run");

        // R10: both starts in one idle cycle
        @(negedge clk);
        sar_data = 12'h3C3;
        convst = 1'b1;
        ctrl_wr = 1'b1;
        ctrl_wdata = 6'b1_11_101;
        @(negedge clk);
        ctrl_wr = 1'b0;
        check("R10 hold immediate", int'(track), 0);
        check("R10 start bit clear", int'(ctrl_o), 6'b0_11_101);
        // R11: convst stays high through and after conversion
        finish_conv(12'h3C3, "both");
        quiet(15, "R11 level does not retrigger");
        convst = 1'b0;
        quiet(4, "R11 falling edge does not start");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule